// File: doc/BRIEF.md
# Internal Address Space Router

This block sits beside the translation path and handles requests that target the non-memory internal segment. The upper bits of the request address choose one of three spaces: CPUID, model-specific registers or I/O ports. The router then turns the request into a physical target. That target is one of four things:

- an internal register slot;
- the PCI configuration-address register;
- a window into PCI configuration space;
- a window onto the I/O port space.

When no target exists, the router reports why instead.

The result is registered and appears exactly one cycle after the request. A response carries at most one outcome flag:

- the internal-register flag;
- a general-protection fault;
- an unmapped configuration-data status;
- a bad-space error.

Any flag other than the internal-register flag leaves the physical address at zero. The current PCI configuration-address value is an input, so configuration-data accesses use whatever value the surrounding logic holds.

Top module: `iasr_router`

## Requirements
- R1: While `rst` is high, and on every cycle with `rsp_valid` low, all response flags and `rsp_paddr` are zero.
- R2: `rsp_valid` equals `req_valid` delayed by one clock, and the response fields belong to the request of the previous cycle.
- R3: The space code is address bits [62:59]: 1 = register space, 2 = I/O space. In register space the index is address bits [58:3]. If that index equals entry i of the table {0x10, 0x1B, 0x174, 0x175, 0x176, 0xC0000080, 0xC0000081, 0xC0000100}, the response gives `rsp_paddr` = (16 + i) × 8 with `rsp_ireg` = 1.
- R4: A register-space index that is not in the table gives `rsp_gp` = 1, with `rsp_ireg` = 0.
- R5: In I/O space the port is the address with bits [62:59] cleared. A 4-byte access (`req_size` = 4) to port 0xCF8 gives `rsp_paddr` = 40 × 8 = 0x140 with `rsp_ireg` = 1.
- R6: An access to port 0xCF8 with any size other than 4 is treated as an ordinary port (R9).
- R7: An access to ports 0xCFC–0xCFF while `cfg_addr[31]` = 1 gives `rsp_paddr` = 0x3000_0000_0000_0000 | (`cfg_addr` & 0x7FFF_FFFC) | port[1:0], with no flag set.
- R8: An access to ports 0xCFC–0xCFF while `cfg_addr[31]` = 0 gives `rsp_unmapped` = 1.
- R9: Any other port gives `rsp_paddr` = 0x2000_0000_0000_0000 | port, with no flag set.
- R10: Space code 0 (CPUID) and space codes 3–15 give `rsp_badspace` = 1.
- R11: An I/O-space port with any bit set above bit 15 gives `rsp_badspace` = 1.
- R12: At most one of `rsp_ireg`, `rsp_gp`, `rsp_unmapped` and `rsp_badspace` is set. When `rsp_gp`, `rsp_unmapped` or `rsp_badspace` is set, `rsp_paddr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 64 | Internal-segment request address |
| req_size | input | 4 | Access size in bytes |
| cfg_addr | input | 32 | Current PCI configuration-address value |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 64 | Routed physical address |
| rsp_ireg | output | 1 | Target is an internal register |
| rsp_gp | output | 1 | General-protection fault, error code 0 |
| rsp_unmapped | output | 1 | Configuration-data access while configuration is disabled |
| rsp_badspace | output | 1 | Unsupported space or oversized port |

## Verification
A bad register-table entry or a wrong window decode shows up as a wrong `rsp_paddr`, or a wrong flag, on the response for that one request, one cycle after it is issued. Since the router keeps no state between requests, an error cannot hide and appear later. It must appear on the response to the stimulus that triggers it. For this reason the stimulus covers every table entry, both sides of the 0xCF8 size test, all four configuration-data ports with the enable bit set and with it clear, and addresses just outside each decoded range.

// File: rtl/iasr_pkg.sv
package iasr_pkg;

    localparam int VA_W      = 64;
    localparam int REG_SHIFT = 3;
    localparam int PFX_LSB   = 56;   // prefix position in the shifted address
    localparam int PFX_W     = 4;
    localparam int PORT_W    = 16;
    localparam int MSR_N     = 8;
    localparam int SIZE_W    = 4;
    localparam int CFG_W     = 32;

    localparam int PFX_VLO = PFX_LSB + REG_SHIFT;
    localparam int PFX_VHI = PFX_VLO + PFX_W - 1;
    localparam logic [VA_W-1:0] PFX_VMASK =
        ((VA_W'(1) << PFX_W) - VA_W'(1)) << PFX_VLO;

    localparam logic [PFX_W-1:0] SPACE_CPUID = PFX_W'(0);
    localparam logic [PFX_W-1:0] SPACE_MSR   = PFX_W'(1);
    localparam logic [PFX_W-1:0] SPACE_IO    = PFX_W'(2);

    localparam logic [PORT_W-1:0] PORT_CFG_ADDR = 16'hCF8;
    localparam logic [PORT_W-1:0] PORT_CFG_DATA = 16'hCFC;

    localparam logic [31:0] MSR_IDX [MSR_N] = '{
        32'h0000_0010, 32'h0000_001B, 32'h0000_0174, 32'h0000_0175,
        32'h0000_0176, 32'hC000_0080, 32'hC000_0081, 32'hC000_0100
    };

    typedef struct packed {
        logic            ireg;
        logic            gp;
        logic            unmapped;
        logic            badspace;
        logic [VA_W-1:0] paddr;
    } route_t;

    function automatic route_t route_none();
        route_t r;
        r = '0;
        return r;
    endfunction

    function automatic logic [VA_W-1:0] reg_slot(input int regnum);
        return VA_W'(regnum) << REG_SHIFT;
    endfunction

endpackage

// File: rtl/iasr_msr_map.sv
module iasr_msr_map
    import iasr_pkg::*;
#(
    parameter int N        = MSR_N,
    parameter int REG_BASE = 16
) (
    input  logic [PFX_LSB-1:0] index,
    output route_t             route
);
    logic [N-1:0] hit_vec;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = (index == PFX_LSB'(MSR_IDX[g]));
    end

    always_comb begin
        route = route_none();
        if (hit_vec == '0) begin
            route.gp = 1'b1;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (hit_vec[i]) begin
                    route.ireg  = 1'b1;
                    route.paddr = reg_slot(REG_BASE + i);
                end
            end
        end
    end
endmodule

// File: rtl/iasr_io_map.sv
module iasr_io_map
    import iasr_pkg::*;
#(
    parameter int              CFGA_REGNUM  = 40,
    parameter logic [VA_W-1:0] IO_WIN_BASE  = 64'h2000_0000_0000_0000,
    parameter logic [VA_W-1:0] CFG_WIN_BASE = 64'h3000_0000_0000_0000
) (
    input  logic [PORT_W-1:0] port,
    input  logic [SIZE_W-1:0] size,
    input  logic [CFG_W-1:0]  cfg,
    output route_t            route
);
    logic is_cfg_addr, is_cfg_data;

    assign is_cfg_addr = (port == PORT_CFG_ADDR) && (size == SIZE_W'(4));
    assign is_cfg_data = (port[PORT_W-1:2] == PORT_CFG_DATA[PORT_W-1:2]);

    always_comb begin
        route = route_none();
        if (is_cfg_addr) begin
            route.ireg  = 1'b1;
            route.paddr = reg_slot(CFGA_REGNUM);
        end else if (is_cfg_data) begin
            if (cfg[CFG_W-1]) begin
                route.paddr = CFG_WIN_BASE
                            | VA_W'({cfg[CFG_W-2:2], 2'b00})
                            | VA_W'(port[1:0]);
            end else begin
                route.unmapped = 1'b1;
            end
        end else begin
            route.paddr = IO_WIN_BASE | VA_W'(port);
        end
    end
endmodule

// File: rtl/iasr_router.sv
module iasr_router
    import iasr_pkg::*;
#(
    parameter int              MSR_REG_BASE = 16,
    parameter int              CFGA_REGNUM  = 40,
    parameter logic [VA_W-1:0] IO_WIN_BASE  = 64'h2000_0000_0000_0000,
    parameter logic [VA_W-1:0] CFG_WIN_BASE = 64'h3000_0000_0000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [CFG_W-1:0]  cfg_addr,
    output logic              rsp_valid,
    output logic [VA_W-1:0]   rsp_paddr,
    output logic              rsp_ireg,
    output logic              rsp_gp,
    output logic              rsp_unmapped,
    output logic              rsp_badspace
);
    logic [PFX_W-1:0] space;
    logic [VA_W-1:0]  port_full;
    logic             port_wide;
    route_t           msr_route, io_route, next_route, cur;

    assign space     = req_vaddr[PFX_VHI:PFX_VLO];
    assign port_full = req_vaddr & ~PFX_VMASK;
    assign port_wide = |(port_full >> PORT_W);

    iasr_msr_map #(.N(MSR_N), .REG_BASE(MSR_REG_BASE)) i_msr (
        .index (req_vaddr[PFX_VLO-1:REG_SHIFT]),
        .route (msr_route)
    );

    iasr_io_map #(
        .CFGA_REGNUM (CFGA_REGNUM),
        .IO_WIN_BASE (IO_WIN_BASE),
        .CFG_WIN_BASE(CFG_WIN_BASE)
    ) i_io (
        .port  (port_full[PORT_W-1:0]),
        .size  (req_size),
        .cfg   (cfg_addr),
        .route (io_route)
    );

    always_comb begin
        next_route = route_none();
        if (space == SPACE_MSR) begin
            next_route = msr_route;
        end else if (space == SPACE_IO && !port_wide) begin
            next_route = io_route;
        end else begin
            next_route.badspace = 1'b1;   // CPUID, unknown space, wide port
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            cur       <= route_none();
        end else begin
            rsp_valid <= req_valid;
            cur       <= req_valid ? next_route : route_none();
        end
    end

    assign rsp_paddr    = cur.paddr;
    assign rsp_ireg     = cur.ireg;
    assign rsp_gp       = cur.gp;
    assign rsp_unmapped = cur.unmapped;
    assign rsp_badspace = cur.badspace;

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (rsp_paddr == '0 && !rsp_ireg && !rsp_gp
                        && !rsp_unmapped && !rsp_badspace));
    a_r12_one_outcome: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_ireg, rsp_gp, rsp_unmapped, rsp_badspace}));
    a_r12_fault_zero: assert property (@(posedge clk) disable iff (rst)
        (rsp_gp || rsp_unmapped || rsp_badspace) |-> rsp_paddr == '0);
    a_r3_slot_aligned: assert property (@(posedge clk) disable iff (rst)
        rsp_ireg |-> rsp_paddr[REG_SHIFT-1:0] == '0);
endmodule

// File: tb/test_iasr_router.sv
module test_iasr_router;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [63:0] req_vaddr;
    logic [3:0]  req_size;
    logic [31:0] cfg_addr;
    logic        rsp_valid;
    logic [63:0] rsp_paddr;
    logic        rsp_ireg, rsp_gp, rsp_unmapped, rsp_badspace;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    iasr_router i_iasr_router (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_size(req_size), .cfg_addr(cfg_addr), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_ireg(rsp_ireg), .rsp_gp(rsp_gp),
        .rsp_unmapped(rsp_unmapped), .rsp_badspace(rsp_badspace)
    );

    // response image: {valid, ireg, gp, unmapped, badspace, paddr}
    typedef logic [68:0] img_t;

    function automatic logic [31:0] tbl(input int i);
        case (i)
            0: return 32'h10;        1: return 32'h1B;
            2: return 32'h174;       3: return 32'h175;
            4: return 32'h176;       5: return 32'hC000_0080;
            6: return 32'hC000_0081; default: return 32'hC000_0100;
        endcase
    endfunction

    function automatic logic [63:0] va_msr(input logic [55:0] idx);
        return (64'd1 << 59) | ({8'd0, idx} << 3);
    endfunction

    function automatic logic [63:0] va_io(input logic [58:0] port);
        return (64'd2 << 59) | {5'd0, port};
    endfunction

    function automatic img_t expect_of(input logic [63:0] va, input logic [3:0] sz,
                                       input logic [31:0] cfg, output string tag);
        logic [3:0]  sp;
        logic [63:0] pt;
        sp = va[62:59];
        pt = va & ~(64'hF << 59);
        if (sp == 4'd1) begin
            for (int i = 0; i < 8; i++)
                if (va[58:3] == {24'd0, tbl(i)}) begin
                    tag = "R3";
                    return {1'b1, 4'b1000, 64'(16 + i) * 64'd8};
                end
            tag = "R4";
            return {1'b1, 4'b0100, 64'd0};
        end
        if (sp != 4'd2 || (pt >> 16) != 0) begin
            tag = (sp == 4'd2) ? "R11" : "R10";
            return {1'b1, 4'b0001, 64'd0};
        end
        if (pt[15:0] == 16'hCF8 && sz == 4'd4) begin
            tag = "R5";
            return {1'b1, 4'b1000, 64'h140};
        end
        if (pt[15:2] == 14'h33F) begin
            if (cfg[31]) begin
                tag = "R7";
                return {1'b1, 4'b0000,
                        64'h3000_0000_0000_0000 | {32'd0, cfg & 32'h7FFF_FFFC} | {62'd0, pt[1:0]}};
            end
            tag = "R8";
            return {1'b1, 4'b0010, 64'd0};
        end
        tag = (pt[15:0] == 16'hCF8) ? "R6" : "R9";
        return {1'b1, 4'b0000, 64'h2000_0000_0000_0000 | pt};
    endfunction

    function automatic img_t actual();
        return {rsp_valid, rsp_ireg, rsp_gp, rsp_unmapped, rsp_badspace, rsp_paddr};
    endfunction

    task automatic compare(input string tag, input img_t got, input img_t exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // drive one request, check its response one clock later (R2 latency)
    task automatic one(input logic [63:0] va, input logic [3:0] sz, input logic [31:0] cfg);
        string tag;
        img_t  exp;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_size = sz; cfg_addr = cfg;
        exp = expect_of(va, sz, cfg, tag);
        @(negedge clk);
        req_valid = 1'b0;
        compare(tag, actual(), exp);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        int unsigned k;
        logic [63:0] va;
        logic [31:0] cfg;
        logic [3:0]  sz;
        seed = 32'd1234;
        void'($urandom(seed));
        rst = 1'b1; req_valid = 1'b1; req_vaddr = va_msr(56'h10);
        req_size = 4'd8; cfg_addr = '0;
        repeat (3) @(negedge clk);
        compare("R1 reset", actual(), '0);
        rst = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        compare("R1 idle", actual(), '0);

        // R3: every table entry; R4: neighbours that are not in the table
        for (int i = 0; i < 8; i++) one(va_msr({24'd0, tbl(i)}), 4'd8, 32'h0);
        one(va_msr(56'h11), 4'd8, 32'h0);
        one(va_msr(56'h1_C000_0080), 4'd8, 32'h0);
        one(va_msr(56'h0), 4'd8, 32'h0);
        // R5 / R6: 0xCF8 size test
        one(va_io(59'hCF8), 4'd4, 32'h0);
        one(va_io(59'hCF8), 4'd2, 32'h0);
        one(va_io(59'hCF8), 4'd1, 32'h8000_0000);
        // R7 / R8: all four data ports, enabled and disabled
        for (int p = 0; p < 4; p++) begin
            one(va_io(59'(16'hCFC + p)), 4'd4, 32'h8001_2347);
            one(va_io(59'(16'hCFC + p)), 4'd1, 32'h7FFF_FFFF);
        end
        // R9: edges around the decoded ports
        one(va_io(59'hCFB), 4'd4, 32'h8000_0000);
        one(va_io(59'hD00), 4'd4, 32'h8000_0000);
        one(va_io(59'hFFFF), 4'd1, 32'h0);
        one(va_io(59'h0), 4'd1, 32'h0);
        // R10 / R11
        one(64'h0000_0000_0000_0010, 4'd8, 32'h0);
        one(64'h1800_0000_0000_0CF8, 4'd4, 32'h0);
        one(64'h7800_0000_0000_0000, 4'd4, 32'h0);
        one(va_io(59'h1_0000), 4'd4, 32'h0);
        one(va_io(59'h1_0CFC), 4'd4, 32'h8000_0000);
        one(64'h8000_0000_0000_0000 | va_io(59'h60), 4'd1, 32'h0);

        // R2: back-to-back, then idle after a request
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va_io(59'h60); req_size = 4'd1; cfg_addr = '0;
        @(negedge clk);
        compare("R2 first", actual(), {1'b1, 4'b0000, 64'h2000_0000_0000_0060});
        req_vaddr = va_msr(56'h174);
        @(negedge clk);
        req_valid = 1'b0;
        compare("R2 second", actual(), {1'b1, 4'b1000, 64'd18 * 64'd8});
        @(negedge clk);
        compare("R2 idle", actual(), '0);

        // random mix (R12 is implied by every exact image comparison)
        for (int n = 0; n < 400; n++) begin
            k   = $urandom % 8;
            cfg = $urandom;
            sz  = 4'(1 << ($urandom % 4));
            case (k)
                0: va = va_msr({24'd0, tbl($urandom % 8)});
                1: va = va_msr({24'd0, $urandom});
                2: va = va_io(59'(16'hCF8 + $urandom % 8));
                3: va = va_io(59'($urandom % 65536));
                4: va = va_io(59'(16'hCFC + $urandom % 4));
                5: va = {1'b0, 4'($urandom), 59'($urandom)};
                6: va = va_io({27'($urandom), 32'($urandom)});
                default: va = {$urandom, $urandom};
            endcase
            one(va, sz, cfg);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule